// File: doc/BRIEF.md
# Frame Alignment Error Toggle Counter

This block estimates the error rate of a 2.048 Mb/s E1-style link by watching the frame alignment words that the receive framer extracts. Such a word arrives in every other 125 µs frame, so 4000 of them arrive each second. Each word is seven bits long and is compared with the fixed pattern 0011011. A word that differs from the pattern is an errored word. Errored words are counted only while the framer reports that it is synchronized.

The block does not expose a count. It flips a single status bit, ERR, each time a group of sixteen errored words has been collected. Software can estimate the bit error rate by counting how often the bit flips over a known time. A hold-off timer runs on a one-millisecond tick supplied from outside. It stops ERR from flipping twice within 128 ms, which puts a ceiling on the error rate the bit can report. When a group completes while the hold-off is still running, the flip waits until the hold-off ends. Errors that arrive during the wait are not carried over.

Top module: `fas_err_toggle`

## Requirements
- R1: A strobed alignment word equal to the pattern 0011011 (word_bits[6] is the first bit, word_bits[0] the last) is not counted as an error.
- R2: A strobed word that differs from the pattern in any number of bit positions, from one to seven, counts as exactly one error.
- R3: ERR changes state once every 16 counted errors, and the error count then starts again from zero.
- R4: Words strobed while in_sync is low are not counted, whatever their content.
- R5: After ERR changes state, at least 128 ms ticks must be seen before ERR may change state again.
- R6: If the 16th error is counted while the hold-off is running, the counter holds at 16 and further errors are discarded. ERR changes state on the second clock edge after the tick that ends the hold-off. The count then restarts from zero, so the discarded errors do not count toward the next group.
- R7: While rst_n is low, ERR is 0, the error count is zero and the hold-off timer is cleared. A group of 16 errors that completes after reset therefore flips ERR without waiting for any ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_stb | input | 1 | One-cycle strobe that marks a received alignment word |
| word_bits | input | 7 | Received alignment bits, first received bit in bit 6 |
| in_sync | input | 1 | High while the framer is synchronized |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| err_flag | output | 1 | ERR status bit, toggles once per group of errors |

## Verification
The comparison is tested with four kinds of word: the correct pattern, words with a single bit inverted at different positions, a word with every bit inverted, and errored words sent while the link is unsynchronized. Together these separate the cases of no error, one error per word regardless of how many bits are wrong, and the synchronization gate. The hold-off is tested by completing a group while the timer is still running. ERR must stay unchanged through the 127th tick and flip only after the 128th tick. Sending 40 errors during a wait, followed by 15 errors after the release, shows whether the surplus errors were wrongly kept. A reset in the middle of a group, followed by a group that must flip ERR at once, shows whether both the count and the timer were cleared.

// File: rtl/fas_err_pkg.sv
// Package: shared constants and helpers for the frame alignment error toggle
// counter. Assumes the 7-bit E1 alignment pattern and a 1 ms timebase.
package fas_err_pkg;

    localparam int unsigned FAS_WORD_W          = 7;
    localparam logic [FAS_WORD_W-1:0] FAS_WORD  = 7'b0011011;
    localparam int unsigned FAS_GROUP_DEFAULT   = 16;
    localparam int unsigned FAS_HOLDOFF_DEFAULT = 128;

    // Width needed to hold values from 0 up to and including max_val.
    function automatic int unsigned span_width(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((1 << w) <= max_val) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/fas_word_check.sv
// Module: fas_word_check
// Compares a strobed alignment word against the expected pattern and raises
// a one-cycle error pulse when at least one bit differs and the link is in
// sync. Assumes word_stb is a single-cycle strobe. This stage is purely
// combinational, so the pulse is in the same cycle as the strobe.
module fas_word_check #(
    parameter int unsigned          WORD_W  = 7,
    parameter logic [WORD_W-1:0]    PATTERN = 7'b0011011
) (
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_bits,
    input  logic              in_sync,
    output logic              word_err
);

    logic [WORD_W-1:0] bit_miss;

    // One mismatch flag per bit position.
    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_bit
        assign bit_miss[gi] = word_bits[gi] ^ PATTERN[gi];
    end

    // Any number of wrong bits counts as one error, and only while synced.
    always_comb begin
        word_err = word_stb && in_sync && (|bit_miss);
    end

endmodule

// File: rtl/fas_err_counter.sv
// Module: fas_err_counter
// Counts errored words up to GROUP and saturates there until the top level
// consumes the group with a release pulse. An error that arrives in the same
// cycle as the release starts the next group at one. Errors that arrive
// while the count is saturated are dropped.
module fas_err_counter #(
    parameter int unsigned GROUP = 16,
    parameter int unsigned CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_err,
    input  logic          release_grp,
    output logic          grp_full,
    output logic [CW-1:0] err_cnt
);

    localparam logic [CW-1:0] CNT_MAX = CW'(GROUP);

    // Group counter: clear on reset, restart on release, saturate at GROUP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (release_grp) begin
            err_cnt <= word_err ? CW'(1) : '0;
        end else if (word_err && (err_cnt != CNT_MAX)) begin
            err_cnt <= err_cnt + CW'(1);
        end
    end

    // A complete group is waiting to be turned into a toggle.
    always_comb begin
        grp_full = (err_cnt == CNT_MAX);
    end

endmodule

// File: rtl/fas_holdoff_timer.sv
// Module: fas_holdoff_timer
// Rate limiter. A start pulse loads HOLDOFF_MS and each ms tick counts one
// off. The limiter is active while any count remains. If a start and a tick
// fall in the same cycle, the start wins, so the full window always follows
// a toggle.
module fas_holdoff_timer #(
    parameter int unsigned HOLDOFF_MS = 128,
    parameter int unsigned TW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          start,
    output logic          active,
    output logic [TW-1:0] remain
);

    localparam logic [TW-1:0] LOAD_VAL = TW'(HOLDOFF_MS);

    // Remaining-time register: load on start, count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= LOAD_VAL;
        end else if (ms_tick && (remain != '0)) begin
            remain <= remain - TW'(1);
        end
    end

    // The window is open for a new toggle only once the count is zero.
    always_comb begin
        active = (remain != '0);
    end

endmodule

// File: rtl/fas_err_toggle.sv
// Module: fas_err_toggle (top)
// Flips err_flag once per group of errored frame alignment words, no more
// often than once per hold-off window. Assumes word_stb and ms_tick are
// single-cycle pulses in the clk domain and that rst_n is synchronous and
// active low.
module fas_err_toggle
    import fas_err_pkg::*;
#(
    parameter int unsigned               WORD_W     = FAS_WORD_W,
    parameter logic [WORD_W-1:0]         PATTERN    = FAS_WORD,
    parameter int unsigned               GROUP      = FAS_GROUP_DEFAULT,
    parameter int unsigned               HOLDOFF_MS = FAS_HOLDOFF_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_bits,
    input  logic              in_sync,
    input  logic              ms_tick,
    output logic              err_flag
);

    localparam int unsigned CW = span_width(GROUP);
    localparam int unsigned TW = span_width(HOLDOFF_MS);

    logic          word_err;
    logic          grp_full;
    logic          hold_active;
    logic          fire;
    logic [CW-1:0] err_cnt;
    logic [TW-1:0] hold_remain;

    fas_word_check #(
        .WORD_W  (WORD_W),
        .PATTERN (PATTERN)
    ) u_check (
        .word_stb  (word_stb),
        .word_bits (word_bits),
        .in_sync   (in_sync),
        .word_err  (word_err)
    );

    fas_err_counter #(
        .GROUP (GROUP),
        .CW    (CW)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_err    (word_err),
        .release_grp (fire),
        .grp_full    (grp_full),
        .err_cnt     (err_cnt)
    );

    fas_holdoff_timer #(
        .HOLDOFF_MS (HOLDOFF_MS),
        .TW         (TW)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .start   (fire),
        .active  (hold_active),
        .remain  (hold_remain)
    );

    // A full group becomes a toggle as soon as the window is free.
    always_comb begin
        fire = grp_full && !hold_active;
    end

    // Status bit: flips once per released group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (fire) begin
            err_flag <= ~err_flag;
        end
    end

endmodule

// File: rtl/fas_err_toggle_chk.sv
// Module: fas_err_toggle_chk
// Property checker bound into fas_err_toggle. It watches the ports and the
// internal count and timer. It keeps its own tick counter to measure the
// spacing between toggles.
module fas_err_toggle_chk #(
    parameter int unsigned       WORD_W     = 7,
    parameter logic [WORD_W-1:0] PATTERN    = 7'b0011011,
    parameter int unsigned       GROUP      = 16,
    parameter int unsigned       HOLDOFF_MS = 128,
    parameter int unsigned       CW         = 5,
    parameter int unsigned       TW         = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_stb,
    input logic [WORD_W-1:0] word_bits,
    input logic              in_sync,
    input logic              ms_tick,
    input logic              err_flag,
    input logic [CW-1:0]     err_cnt,
    input logic [TW-1:0]     hold_remain
);

    logic          prev_flag;
    logic          seen_toggle;
    logic [TW:0]   ticks_since;
    logic          flipped;

    // Own record of the previous flag, the first toggle and ticks since the last toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_flag   <= 1'b0;
            seen_toggle <= 1'b0;
            ticks_since <= '0;
        end else begin
            prev_flag <= err_flag;
            if (err_flag != prev_flag) begin
                seen_toggle <= 1'b1;
                ticks_since <= '0;
            end else if (ms_tick && (ticks_since != {(TW+1){1'b1}})) begin
                ticks_since <= ticks_since + 1'b1;
            end
        end
    end

    always_comb begin
        flipped = (err_flag != prev_flag);
    end

    assert_match_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && word_bits == PATTERN) |=> (err_cnt <= $past(err_cnt)));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt <= $past(err_cnt) + 1'b1) || (err_cnt <= 1));

    assert_toggle_after_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag != $past(err_flag)) |-> ($past(err_cnt) == CW'(GROUP)));

    assert_unsync_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !in_sync) |=> (err_cnt <= $past(err_cnt)));

    assert_holdoff_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flipped && seen_toggle) |-> (ticks_since >= (TW+1)'(HOLDOFF_MS)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= CW'(GROUP));

    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (!err_flag && err_cnt == '0 && hold_remain == '0));

endmodule

bind fas_err_toggle fas_err_toggle_chk #(
    .WORD_W     (WORD_W),
    .PATTERN    (PATTERN),
    .GROUP      (GROUP),
    .HOLDOFF_MS (HOLDOFF_MS),
    .CW         (CW),
    .TW         (TW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_stb    (word_stb),
    .word_bits   (word_bits),
    .in_sync     (in_sync),
    .ms_tick     (ms_tick),
    .err_flag    (err_flag),
    .err_cnt     (err_cnt),
    .hold_remain (hold_remain)
);

// File: tb/fas_err_toggle_tb.sv
// Bench for fas_err_toggle: a vector table followed by directed tests of the
// hold-off boundary, the saturation behaviour and reset.
module fas_err_toggle_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_stb = 1'b0;
    logic [6:0] word_bits = 7'b0011011;
    logic       in_sync = 1'b0;
    logic       ms_tick = 1'b0;
    logic       err_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fas_err_toggle u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_stb  (word_stb),
        .word_bits (word_bits),
        .in_sync   (in_sync),
        .ms_tick   (ms_tick),
        .err_flag  (err_flag)
    );

    // Vector fields: bits[24:18], sync[17], ticks[16:9], words[8:1], exp[0].
    // The ticks are applied first, then the words, then err_flag is checked.
    localparam int NVEC = 8;
    localparam logic [24:0] VEC [NVEC] = '{
        {7'b0011011, 1'b1, 8'd0,   8'd20, 1'b0},  // R1 correct words only
        {7'b0011010, 1'b1, 8'd0,   8'd15, 1'b0},  // R2 single bit, 15 errors
        {7'b1100100, 1'b1, 8'd0,   8'd1,  1'b1},  // R2 all bits wrong, 16th error
        {7'b0011001, 1'b1 ^ 1'b1, 8'd0, 8'd20, 1'b1},  // R4 unsynced errors
        {7'b0111011, 1'b1, 8'd0,   8'd16, 1'b1},  // R6 group held by hold-off
        {7'b0011011, 1'b1, 8'd128, 8'd0,  1'b0},  // R6 released after window
        {7'b0011011, 1'b1, 8'd128, 8'd20, 1'b0},  // R1 nothing pending
        {7'b0001011, 1'b1, 8'd0,   8'd16, 1'b1}   // R3 fresh group, window free
    };

    task automatic send_words(input logic [6:0] b, input logic s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            word_bits = b;
            in_sync   = s;
            word_stb  = 1'b1;
            @(negedge clk);
            word_stb  = 1'b0;
        end
    endtask

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic settle_and_check(input logic exp, input string req);
        repeat (3) @(negedge clk);
        checks++;
        if (err_flag !== exp) begin
            failures++;
            $display("FAIL %s: err_flag actual=%b expected=%b", req, err_flag, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        settle_and_check(1'b0, "R7 reset state");
        rst_n = 1'b1;
        in_sync = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            send_ticks(int'(VEC[v][16:9]));
            send_words(VEC[v][24:18], VEC[v][17], int'(VEC[v][8:1]));
            settle_and_check(VEC[v][0], $sformatf("R1/R2/R3/R4/R6 vector %0d", v));
        end

        // R5: a full group waits through 127 ticks and is released on the 128th.
        send_words(7'b0011111, 1'b1, 16);
        send_ticks(127);
        settle_and_check(1'b1, "R5 held at 127 ticks");
        send_ticks(1);
        settle_and_check(1'b0, "R5 released at 128 ticks");

        // R6: surplus errors during the wait are discarded.
        send_words(7'b1011011, 1'b1, 40);
        settle_and_check(1'b0, "R6 no toggle while held");
        send_ticks(128);
        settle_and_check(1'b1, "R6 single toggle for 40 errors");
        send_ticks(128);
        send_words(7'b0010011, 1'b1, 15);
        settle_and_check(1'b1, "R6 surplus not carried");
        send_words(7'b0010011, 1'b1, 1);
        settle_and_check(1'b0, "R3 16th error toggles");

        // R7: reset in mid-group clears the count and the hold-off.
        send_words(7'b0011010, 1'b1, 10);
        @(negedge clk);
        rst_n = 1'b0;
        settle_and_check(1'b0, "R7 reset clears flag");
        rst_n = 1'b1;
        send_words(7'b0011010, 1'b1, 6);
        settle_and_check(1'b0, "R7 count cleared by reset");
        send_words(7'b0011010, 1'b1, 10);
        settle_and_check(1'b1, "R7 hold-off cleared by reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule